// File: doc/BRIEF.md
# Transfer Status and Writeback Generator

This block sits behind the two data mover directions of a DMA engine and turns their transfer-done reports into completion bookkeeping. Each report names a queue, the index of the descriptor that just finished, and whether the host wants a writeback for it. For every accepted report the block records that index as the queue's completed pointer. Software can read the completed pointer over a simple register bus. Interrupts are not produced.

When a report asks for a writeback, the block forms a small write command. The command carries the completed index as immediate data and targets a per-queue host address that software programs. It sends the command on the device-to-host command port. That port also carries ordinary device-to-host data commands from upstream, so the block merges the two streams. Pending writebacks are buffered in a short queue and always win the port. Reports from the two directions that arrive together are taken in turn.

The register bus gives each queue a 256-byte page at `{qid, offset}`. Bit 7 of the offset selects the direction: 0 is device-to-host and 1 is host-to-device. Within a direction, offset 0x28 is the completed pointer and is read-only. Offsets 0x30 and 0x34 hold the low and high 32 bits of the writeback address.

Top module: `dm_status_wb`

## Requirements
- R1: After reset every completed pointer and every writeback address reads 0. `cmd_valid` is 0 while `usr_valid` is 0, and `reg_rvalid` is 0.
- R2: An accepted status sets the completed pointer of its queue and direction to the status index. A read issued in the following cycle or later returns the new value, zero-extended.
- R3: An accepted status with writeback enable set produces exactly one command on the shared port. That command has `cmd_wb`=1, `cmd_dst` equal to the queue's writeback address for that direction as it stood when the status was accepted, `cmd_wbdata` equal to the index zero-extended, `cmd_len`=4 and `cmd_src`=0.
- R4: An accepted status with writeback enable clear produces no command on the shared port.
- R5: At most one status is accepted per cycle. When both directions are valid, the direction not served at the most recent acceptance is taken. At the first tie after reset the host-to-device side goes first.
- R6: While any writeback is pending, `cmd_valid` is 1 with `cmd_wb`=1 and `usr_ready` is 0.
- R7: With no writeback pending, regular commands pass through unchanged. In that case `cmd_valid`=`usr_valid`, `cmd_wb`=0 and `usr_ready`=`cmd_ready`.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, a writeback command on the port does not change.
- R9: Writes to a completed-pointer offset have no effect. Reads of unmapped offsets return 0.
- R10: Writebacks leave the port in acceptance order. When WB_DEPTH writebacks are pending, neither status input is accepted.
- R11: `reg_rvalid` is 1 exactly in the cycle after `reg_rd` and carries the data for the address given with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h2d_st_valid | input | 1 | Host-to-device status present |
| h2d_st_ready | output | 1 | Host-to-device status taken this cycle |
| h2d_st_qid | input | QID_W | Queue of the host-to-device status |
| h2d_st_idx | input | IDX_W | Descriptor index of the host-to-device status |
| h2d_st_wben | input | 1 | Writeback requested for the host-to-device status |
| d2h_st_valid | input | 1 | Device-to-host status present |
| d2h_st_ready | output | 1 | Device-to-host status taken this cycle |
| d2h_st_qid | input | QID_W | Queue of the device-to-host status |
| d2h_st_idx | input | IDX_W | Descriptor index of the device-to-host status |
| d2h_st_wben | input | 1 | Writeback requested for the device-to-host status |
| usr_valid | input | 1 | Regular device-to-host command present |
| usr_ready | output | 1 | Regular command taken |
| usr_src | input | ADDR_W | Regular command source address |
| usr_dst | input | ADDR_W | Regular command destination address |
| usr_len | input | LEN_W | Regular command byte count |
| cmd_valid | output | 1 | Shared command port valid |
| cmd_ready | input | 1 | Shared command port ready |
| cmd_src | output | ADDR_W | Command source address |
| cmd_dst | output | ADDR_W | Command destination address |
| cmd_len | output | LEN_W | Command byte count |
| cmd_wb | output | 1 | Command is a writeback carrying immediate data |
| cmd_wbdata | output | REG_DW | Immediate writeback data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | QID_W+8 | Register address {qid, offset} |
| reg_wdata | input | REG_DW | Register write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | REG_DW | Read data |

## Verification
The block is driven with single reports from each direction, with and without writeback. These show that the pointer update and the command generation are separate effects. Simultaneous reports on both sides expose any bias in the alternation. Holding the port busy until the writeback buffer fills shows the stall on the status side and proves that commands are held steady under backpressure. A regular command raised while writebacks are queued tells priority apart from plain pass-through. A long randomised mix of reports, regular commands and port stalls is compared every cycle against a behavioural model, followed by a sweep of all pointer registers.

// File: rtl/dm_wb_pkg.sv
package dm_wb_pkg;

  typedef enum logic {
    DIR_D2H = 1'b0,
    DIR_H2D = 1'b1
  } dm_dir_e;

  // offsets within one direction's half of a queue page (bit 7 = direction)
  localparam logic [6:0] OFF_CMPL = 7'h28;
  localparam logic [6:0] OFF_WBLO = 7'h30;
  localparam logic [6:0] OFF_WBHI = 7'h34;

  // tie-break: host-to-device wins unless it was served last
  function automatic logic pick_h2d(input logic h_req, input logic d_req,
                                    input logic last_was_h2d);
    return h_req && (!d_req || !last_was_h2d);
  endfunction

endpackage

// File: rtl/dm_wb_arb.sv
module dm_wb_arb
  import dm_wb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    h2d_req,
  input  logic    d2h_req,
  input  logic    take_ok,
  output logic    h2d_acc,
  output logic    d2h_acc,
  output dm_dir_e acc_dir
);

  logic last_h2d_q;
  logic sel_h2d;

  assign sel_h2d = pick_h2d(h2d_req, d2h_req, last_h2d_q);
  assign h2d_acc = take_ok && sel_h2d;
  assign d2h_acc = take_ok && d2h_req && !sel_h2d;
  assign acc_dir = sel_h2d ? DIR_H2D : DIR_D2H;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_h2d_q <= 1'b0;
    end else if (h2d_acc) begin
      last_h2d_q <= 1'b1;
    end else if (d2h_acc) begin
      last_h2d_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dm_wb_regs.sv
module dm_wb_regs
  import dm_wb_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int QID_W  = 4,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 64,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  dm_dir_e           upd_dir,
  input  logic [QID_W-1:0]  upd_qid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  dm_dir_e           look_dir,
  input  logic [QID_W-1:0]  look_qid,
  output logic [ADDR_W-1:0] look_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [QID_W+7:0]  reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [REG_DW-1:0] reg_rdata
);

  localparam int WBA_W = 2 * REG_DW;

  logic [IDX_W-1:0] cmpl_q [2][NUM_Q];
  logic [WBA_W-1:0] wba_q  [2][NUM_Q];

  logic [QID_W-1:0]  rq_qid;
  logic              rq_dir;
  logic [6:0]        rq_off;
  logic [REG_DW-1:0] rd_mux;

  assign rq_qid = reg_addr[QID_W+7:8];
  assign rq_dir = reg_addr[7];
  assign rq_off = reg_addr[6:0];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic hit_upd;
      logic hit_reg;
      assign hit_upd = upd_en && (upd_dir == ((d != 0) ? DIR_H2D : DIR_D2H)) &&
                       (upd_qid == QID_W'(q));
      assign hit_reg = reg_wr && (rq_dir == 1'(d)) && (rq_qid == QID_W'(q));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmpl_q[d][q] <= '0;
          wba_q[d][q]  <= '0;
        end else begin
          if (hit_upd) cmpl_q[d][q] <= upd_idx;
          if (hit_reg && rq_off == OFF_WBLO) wba_q[d][q][REG_DW-1:0]     <= reg_wdata;
          if (hit_reg && rq_off == OFF_WBHI) wba_q[d][q][WBA_W-1:REG_DW] <= reg_wdata;
        end
      end
    end
  end

  assign look_addr = wba_q[look_dir][look_qid][ADDR_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (32'(rq_qid) < NUM_Q) begin
      case (rq_off)
        OFF_CMPL: rd_mux = REG_DW'(cmpl_q[rq_dir][rq_qid]);
        OFF_WBLO: rd_mux = wba_q[rq_dir][rq_qid][REG_DW-1:0];
        OFF_WBHI: rd_mux = wba_q[rq_dir][rq_qid][WBA_W-1:REG_DW];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/dm_wb_fifo.sv
module dm_wb_fifo #(
  parameter int W     = 80,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_p];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= wrap_inc(wr_p);
      if (do_pop)  rd_p <= wrap_inc(rd_p);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/dm_wb_outmux.sv
module dm_wb_outmux #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 20,
  parameter int IDX_W  = 16,
  parameter int REG_DW = 32
) (
  input  logic              wb_have,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [IDX_W-1:0]  wb_idx,
  output logic              wb_take,
  input  logic              usr_valid,
  output logic              usr_ready,
  input  logic [ADDR_W-1:0] usr_src,
  input  logic [ADDR_W-1:0] usr_dst,
  input  logic [LEN_W-1:0]  usr_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_wb,
  output logic [REG_DW-1:0] cmd_wbdata
);

  localparam logic [LEN_W-1:0] WB_BYTES = LEN_W'(REG_DW / 8);

  assign wb_take   = wb_have && cmd_ready;
  assign usr_ready = !wb_have && cmd_ready;

  always_comb begin
    if (wb_have) begin
      cmd_valid  = 1'b1;
      cmd_src    = '0;
      cmd_dst    = wb_addr;
      cmd_len    = WB_BYTES;
      cmd_wb     = 1'b1;
      cmd_wbdata = REG_DW'(wb_idx);
    end else begin
      cmd_valid  = usr_valid;
      cmd_src    = usr_src;
      cmd_dst    = usr_dst;
      cmd_len    = usr_len;
      cmd_wb     = 1'b0;
      cmd_wbdata = '0;
    end
  end

endmodule

// File: rtl/dm_status_wb.sv
module dm_status_wb
  import dm_wb_pkg::*;
#(
  parameter int NUM_Q    = 16,
  parameter int IDX_W    = 16,
  parameter int ADDR_W   = 64,
  parameter int LEN_W    = 20,
  parameter int WB_DEPTH = 4,
  parameter int REG_DW   = 32,
  localparam int QID_W   = $clog2(NUM_Q),
  localparam int RA_W    = QID_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h2d_st_valid,
  output logic              h2d_st_ready,
  input  logic [QID_W-1:0]  h2d_st_qid,
  input  logic [IDX_W-1:0]  h2d_st_idx,
  input  logic              h2d_st_wben,
  input  logic              d2h_st_valid,
  output logic              d2h_st_ready,
  input  logic [QID_W-1:0]  d2h_st_qid,
  input  logic [IDX_W-1:0]  d2h_st_idx,
  input  logic              d2h_st_wben,
  input  logic              usr_valid,
  output logic              usr_ready,
  input  logic [ADDR_W-1:0] usr_src,
  input  logic [ADDR_W-1:0] usr_dst,
  input  logic [LEN_W-1:0]  usr_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_wb,
  output logic [REG_DW-1:0] cmd_wbdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [REG_DW-1:0] reg_rdata
);

  localparam int ENT_W = ADDR_W + IDX_W;

  // named internal events
  logic             h2d_acc, d2h_acc, any_acc;
  dm_dir_e          acc_dir;
  logic [QID_W-1:0] acc_qid;
  logic [IDX_W-1:0] acc_idx;
  logic             acc_wben;
  logic [ADDR_W-1:0] acc_wbaddr;
  logic             wbq_push, wbq_pop, wbq_full, wbq_empty;
  logic [ENT_W-1:0] wbq_head;

  dm_wb_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .h2d_req (h2d_st_valid),
    .d2h_req (d2h_st_valid),
    .take_ok (!wbq_full),
    .h2d_acc (h2d_acc),
    .d2h_acc (d2h_acc),
    .acc_dir (acc_dir)
  );

  assign h2d_st_ready = h2d_acc;
  assign d2h_st_ready = d2h_acc;
  assign any_acc      = h2d_acc || d2h_acc;
  assign acc_qid      = h2d_acc ? h2d_st_qid  : d2h_st_qid;
  assign acc_idx      = h2d_acc ? h2d_st_idx  : d2h_st_idx;
  assign acc_wben     = h2d_acc ? h2d_st_wben : d2h_st_wben;
  assign wbq_push     = any_acc && acc_wben;

  dm_wb_regs #(
    .NUM_Q  (NUM_Q),
    .QID_W  (QID_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .REG_DW (REG_DW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (any_acc),
    .upd_dir    (acc_dir),
    .upd_qid    (acc_qid),
    .upd_idx    (acc_idx),
    .look_dir   (acc_dir),
    .look_qid   (acc_qid),
    .look_addr  (acc_wbaddr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata)
  );

  dm_wb_fifo #(
    .W     (ENT_W),
    .DEPTH (WB_DEPTH)
  ) u_wbq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wbq_push),
    .push_data ({acc_wbaddr, acc_idx}),
    .pop       (wbq_pop),
    .head      (wbq_head),
    .full      (wbq_full),
    .empty     (wbq_empty)
  );

  dm_wb_outmux #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .IDX_W  (IDX_W),
    .REG_DW (REG_DW)
  ) u_out (
    .wb_have    (!wbq_empty),
    .wb_addr    (wbq_head[ENT_W-1:IDX_W]),
    .wb_idx     (wbq_head[IDX_W-1:0]),
    .wb_take    (wbq_pop),
    .usr_valid  (usr_valid),
    .usr_ready  (usr_ready),
    .usr_src    (usr_src),
    .usr_dst    (usr_dst),
    .usr_len    (usr_len),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_src    (cmd_src),
    .cmd_dst    (cmd_dst),
    .cmd_len    (cmd_len),
    .cmd_wb     (cmd_wb),
    .cmd_wbdata (cmd_wbdata)
  );

endmodule

// File: rtl/dm_status_wb_chk.sv
module dm_status_wb_chk #(
  parameter int ADDR_W = 64,
  parameter int REG_DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h2d_st_valid,
  input logic              d2h_st_valid,
  input logic              h2d_acc,
  input logic              d2h_acc,
  input logic              wbq_full,
  input logic              wbq_empty,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_wb,
  input logic [ADDR_W-1:0] cmd_dst,
  input logic [REG_DW-1:0] cmd_wbdata,
  input logic              usr_ready,
  input logic              reg_rd,
  input logic              reg_rvalid
);

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(h2d_acc && d2h_acc)); // R5

  AST_ALT_AFTER_H2D: assert property (@(posedge clk) disable iff (!rst_n)
    (h2d_acc && d2h_st_valid) |=> !h2d_acc); // R5

  AST_ALT_AFTER_D2H: assert property (@(posedge clk) disable iff (!rst_n)
    (d2h_acc && h2d_st_valid) |=> !d2h_acc); // R5

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wbq_full |-> (!h2d_acc && !d2h_acc)); // R10

  AST_WB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !wbq_empty |-> (cmd_valid && cmd_wb && !usr_ready)); // R6

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_wb && !cmd_ready) |=>
      (cmd_valid && cmd_wb && $stable(cmd_dst) && $stable(cmd_wbdata))); // R8

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R11

endmodule

bind dm_status_wb dm_status_wb_chk #(
  .ADDR_W (ADDR_W),
  .REG_DW (REG_DW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .h2d_st_valid (h2d_st_valid),
  .d2h_st_valid (d2h_st_valid),
  .h2d_acc      (h2d_acc),
  .d2h_acc      (d2h_acc),
  .wbq_full     (wbq_full),
  .wbq_empty    (wbq_empty),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_wb       (cmd_wb),
  .cmd_dst      (cmd_dst),
  .cmd_wbdata   (cmd_wbdata),
  .usr_ready    (usr_ready),
  .reg_rd       (reg_rd),
  .reg_rvalid   (reg_rvalid)
);

// File: tb/dm_status_wb_bench.sv
`timescale 1ns/1ps
module dm_status_wb_bench;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h2d_st_valid = 0, h2d_st_ready, h2d_st_wben = 0;
  logic [3:0]  h2d_st_qid = 0;
  logic [15:0] h2d_st_idx = 0;
  logic        d2h_st_valid = 0, d2h_st_ready, d2h_st_wben = 0;
  logic [3:0]  d2h_st_qid = 0;
  logic [15:0] d2h_st_idx = 0;
  logic        usr_valid = 0, usr_ready;
  logic [63:0] usr_src = 0, usr_dst = 0;
  logic [19:0] usr_len = 0;
  logic        cmd_valid, cmd_ready = 0, cmd_wb;
  logic [63:0] cmd_src, cmd_dst;
  logic [19:0] cmd_len;
  logic [31:0] cmd_wbdata;
  logic        reg_wr = 0, reg_rd = 0, reg_rvalid;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  always #2 clk = ~clk;

  dm_status_wb u_dm_status_wb (.*);

  // behavioural reference
  logic [15:0] m_cmpl [2][16];
  logic [63:0] m_wba  [2][16];
  logic [79:0] m_q [$];
  bit          m_last_h2d;
  bit          m_rd_pend;
  logic [31:0] m_rd_exp;
  string       m_rd_tag;
  string       rd_tag = "R11";
  bit          took_h, took_d, took_u;
  int          n_checks = 0, n_errors = 0;
  bit          done = 0;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(logic [11:0] a);
    case (a[6:0])
      7'h28:   return {16'h0, m_cmpl[a[7]][a[11:8]]};
      7'h30:   return m_wba[a[7]][a[11:8]][31:0];
      7'h34:   return m_wba[a[7]][a[11:8]][63:32];
      default: return 32'h0;
    endcase
  endfunction

  // one cycle: settle, compare, advance model, move to next negedge
  task automatic step();
    bit full, sel_h, eh, ed, npend;
    logic [31:0] nexp;
    string ntag;
    logic [79:0] f;
    #1;
    full  = (m_q.size() >= DEPTH);
    sel_h = h2d_st_valid && (!d2h_st_valid || !m_last_h2d);
    eh    = !full && sel_h;
    ed    = !full && d2h_st_valid && !sel_h;
    chk(full ? "R10" : "R5", "h2d_st_ready", h2d_st_ready, eh);
    chk(full ? "R10" : "R5", "d2h_st_ready", d2h_st_ready, ed);
    if (m_q.size() != 0) begin
      f = m_q[0];
      chk("R6", "cmd_valid", cmd_valid, 1);
      chk("R6", "usr_ready", usr_ready, 0);
      chk("R3", "cmd_wb", cmd_wb, 1);
      chk("R3", "cmd_dst", cmd_dst, f[79:16]);
      chk("R3", "cmd_wbdata", cmd_wbdata, {48'h0, f[15:0]});
      chk("R3", "cmd_len", cmd_len, 4);
      chk("R3", "cmd_src", cmd_src, 0);
    end else begin
      chk("R7", "cmd_valid", cmd_valid, usr_valid);
      chk("R4", "cmd_wb", cmd_wb, 0);
      chk("R7", "usr_ready", usr_ready, cmd_ready);
      if (usr_valid) begin
        chk("R7", "cmd_src", cmd_src, usr_src);
        chk("R7", "cmd_dst", cmd_dst, usr_dst);
        chk("R7", "cmd_len", cmd_len, usr_len);
      end
    end
    chk("R11", "reg_rvalid", reg_rvalid, m_rd_pend);
    if (m_rd_pend) chk(m_rd_tag, "reg_rdata", reg_rdata, m_rd_exp);
    took_h = eh;
    took_d = ed;
    took_u = usr_valid && (m_q.size() == 0) && cmd_ready;
    npend = reg_rd;
    nexp  = ref_read(reg_addr);
    ntag  = rd_tag;
    if (m_q.size() != 0 && cmd_ready) void'(m_q.pop_front());
    if (eh) begin
      m_cmpl[1][h2d_st_qid] = h2d_st_idx;
      if (h2d_st_wben) m_q.push_back({m_wba[1][h2d_st_qid], h2d_st_idx});
      m_last_h2d = 1;
    end
    if (ed) begin
      m_cmpl[0][d2h_st_qid] = d2h_st_idx;
      if (d2h_st_wben) m_q.push_back({m_wba[0][d2h_st_qid], d2h_st_idx});
      m_last_h2d = 0;
    end
    if (reg_wr && reg_addr[6:0] == 7'h30) m_wba[reg_addr[7]][reg_addr[11:8]][31:0]  = reg_wdata;
    if (reg_wr && reg_addr[6:0] == 7'h34) m_wba[reg_addr[7]][reg_addr[11:8]][63:32] = reg_wdata;
    m_rd_pend = npend;
    m_rd_exp  = nexp;
    m_rd_tag  = ntag;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, string tag);
    reg_rd = 1; reg_addr = a; rd_tag = tag;
    step();
    reg_rd = 0;
    step();
  endtask

  task automatic st_h2d(logic [3:0] q, logic [15:0] i, logic w);
    h2d_st_valid = 1; h2d_st_qid = q; h2d_st_idx = i; h2d_st_wben = w;
    do step(); while (!took_h);
    h2d_st_valid = 0;
  endtask

  task automatic st_d2h(logic [3:0] q, logic [15:0] i, logic w);
    d2h_st_valid = 1; d2h_st_qid = q; d2h_st_idx = i; d2h_st_wben = w;
    do step(); while (!took_d);
    d2h_st_valid = 0;
  endtask

  task automatic st_both(logic [3:0] qh, logic [15:0] ih, logic [3:0] qd, logic [15:0] id);
    h2d_st_valid = 1; h2d_st_qid = qh; h2d_st_idx = ih; h2d_st_wben = 1;
    d2h_st_valid = 1; d2h_st_qid = qd; d2h_st_idx = id; d2h_st_wben = 1;
    while (h2d_st_valid || d2h_st_valid) begin
      step();
      if (took_h) h2d_st_valid = 0;
      if (took_d) d2h_st_valid = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    for (int d = 0; d < 2; d++)
      for (int q = 0; q < 16; q++) begin
        m_cmpl[d][q] = '0;
        m_wba[d][q]  = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "cmd_valid after reset", cmd_valid, 0);
    chk("R1", "reg_rvalid after reset", reg_rvalid, 0);
    @(negedge clk);
    rd(12'h0A8, "R1");
    rd(12'hF30, "R1");
    rd(12'h728, "R1");

    cmd_ready = 1;
    wr(12'h530, 32'h1000_0040); wr(12'h534, 32'h0000_0001);
    wr(12'h3B0, 32'h2000_0080); wr(12'h3B4, 32'h0000_0002);
    wr(12'h9B0, 32'h3000_00C0); wr(12'h930, 32'h4000_0100);
    rd(12'h3B0, "R11");

    st_h2d(4'd3, 16'd7, 1'b1);
    idle(2);
    rd(12'h3A8, "R2");

    st_d2h(4'd5, 16'd9, 1'b0);
    #1; chk("R4", "no command after plain status", cmd_valid, 0);
    @(negedge clk);
    idle(1);
    rd(12'h528, "R2");

    // both sides at once, port stalled until the buffer fills
    cmd_ready = 0;
    st_both(4'd9, 16'h0011, 4'd9, 16'h0022);
    st_both(4'd3, 16'h0012, 4'd5, 16'h0023);
    h2d_st_valid = 1; h2d_st_qid = 4'd3; h2d_st_idx = 16'h0013; h2d_st_wben = 1;
    #1; held = cmd_dst;
    @(negedge clk);
    idle(3);
    #1; chk("R8", "cmd_dst under stall", cmd_dst, held);
    chk("R10", "h2d stalled when full", h2d_st_ready, 0);
    @(negedge clk);
    cmd_ready = 1;
    do step(); while (!took_h);
    h2d_st_valid = 0;

    // regular command raised while writebacks wait
    usr_valid = 1; usr_src = 64'hAAAA_0000; usr_dst = 64'hBBBB_0000; usr_len = 20'd512;
    do step(); while (!took_u);
    usr_valid = 0;
    chk("R6", "writebacks drained before user command", m_q.size(), 0);
    usr_valid = 1; usr_src = 64'h1234; usr_dst = 64'h5678; usr_len = 20'd64;
    cmd_ready = 0; idle(2); cmd_ready = 1;
    do step(); while (!took_u);
    usr_valid = 0;

    wr(12'h3A8, 32'hFFFF);
    rd(12'h3A8, "R9");
    wr(12'h328, 32'h00AB);
    rd(12'h328, "R9");
    rd(12'h3C0, "R9");

    for (int k = 0; k < 32; k++) begin
      wr({k[3:0], k[4], 7'h30}, $urandom);
      wr({k[3:0], k[4], 7'h34}, $urandom);
    end
    for (int i = 0; i < 600; i++) begin
      if (!h2d_st_valid && ($urandom % 3 == 0)) begin
        h2d_st_valid = 1; h2d_st_qid = 4'($urandom); h2d_st_idx = 16'($urandom); h2d_st_wben = 1'($urandom);
      end
      if (!d2h_st_valid && ($urandom % 3 == 0)) begin
        d2h_st_valid = 1; d2h_st_qid = 4'($urandom); d2h_st_idx = 16'($urandom); d2h_st_wben = 1'($urandom);
      end
      if (!usr_valid && ($urandom % 4 == 0)) begin
        usr_valid = 1; usr_src = {$urandom, $urandom}; usr_dst = {$urandom, $urandom}; usr_len = 20'($urandom);
      end
      cmd_ready = ($urandom % 4) != 0;
      step();
      if (took_h) h2d_st_valid = 0;
      if (took_d) d2h_st_valid = 0;
      if (took_u) usr_valid = 0;
    end
    cmd_ready = 1;
    while (h2d_st_valid || d2h_st_valid || usr_valid) begin
      step();
      if (took_h) h2d_st_valid = 0;
      if (took_d) d2h_st_valid = 0;
      if (took_u) usr_valid = 0;
    end
    idle(6);
    for (int k = 0; k < 32; k++) rd({k[3:0], k[4], 7'h28}, "R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule